// File: doc/BRIEF.md
# 8-bit ALU with Registered Flag Byte

This block does the byte-wide arithmetic and logic work of a small processor core. It takes two operands and a four-bit operation code. It returns the result on the same cycle, together with a write-enable that tells the surrounding datapath whether the result should be stored. It also keeps an eight-bit flag byte in a register. That register is updated on the clock edge at which the execute strobe is high.

The flag byte is also the carry source for the carry-using operations, so chains of additions or subtractions work across several cycles. Each operation defines only some of the flag bits. The bits it does not define keep their previous value. A few bits are set-only for certain operations: they are raised on one condition and otherwise left as they were.

The interface is plain control and data, with no handshake. A strobe either executes in its cycle or is absent, and the block never applies back-pressure. Instruction decode, the accumulator and memory access belong to the surrounding core.

Top module: `alu8_flagged`

## Requirements
- R1: While reset is low, the flag byte is 0x00. Flag layout: bit7 sign S, bit6 zero Z, bit4 half-carry H, bit3 extension carry X, bit2 overflow/parity V, bit1 subtract N, bit0 carry C. Bit5 is never written and keeps its value.
- R2: Increment (op 0) gives a+1 mod 256. S is result bit7. Z is set when the result is zero. H is set when the result's low nibble is zero. X is set when a is 0xFF. V is set when a is 0x7F and held otherwise. N and C are held.
- R3: Decrement (op 1) gives a-1 mod 256. S, Z and H follow the rules of R2. X is set when a is 0x00. N is set to 1. V is set when a is 0x80 and held otherwise. C is held.
- R4: Add (op 2) and add-with-carry (op 3; carry-in is the registered C) give a+b(+C) mod 256. H is the carry out of bit3. C and X both take the carry out of bit7. V is the carry out of bit7 XOR the carry into bit7. N is cleared.
- R5: Subtract (op 4) gives a-b mod 256, with N=1. H is set when a's low nibble is below b's. C is set when unsigned a is below b. X is set on that borrow and held otherwise. V is set when the signed difference lies outside -128..127.
- R6: Subtract-with-borrow (op 5) forms t=b+C as a 9-bit value. The result is a-t. H compares a's low nibble with t's low nibble. C is set when a is below t. V checks the signed a-b-C against -128..127. N is set to 1. X is held.
- R7: AND (op 6), XOR (op 7) and OR (op 8) set S and Z from the result. V is 1 when the result has an even number of one bits. N, C and X are cleared. H is 1 for AND and 0 for XOR and OR.
- R8: Compare (op 9) updates the flags exactly as subtract (R5) does, and holds the write-enable low.
- R9: The flag byte changes only on a rising clock edge with the execute strobe high and an op code of 0..9. Without the strobe, or with op codes 10..15, it is held.
- R10: The write-enable is high exactly when the execute strobe is high and the op code is 0..8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe; flags update at the next edge |
| op_i | input | 4 | Operation code (0..9 defined) |
| opa_i | input | 8 | First operand (minuend / incremented value) |
| opb_i | input | 8 | Second operand |
| result_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Result write-enable |
| flags_o | output | 8 | Registered flag byte |

## Verification
The cases that are hardest to reach are those that depend on flags left by an earlier operation. These are the carry-in of add-with-carry and subtract-with-borrow, and the held or set-only behaviour of V and X. The corner where a set carry-in turns a subtrahend of 0xFF into 0x100 is one of them. The stimulus chains operations on purpose so that C and X are first set or cleared: an add that overflows, then a carry-using op; a subtract that borrows, then a subtract-with-borrow from 0x00 by 0xFF. A long random sequence follows, in which each operation inherits whatever flags the previous one left. The bench model carries its own flag state across the whole sequence.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_INC = 4'd0, OP_DEC = 4'd1, OP_ADD = 4'd2, OP_ADC = 4'd3,
    OP_SUB = 4'd4, OP_SBC = 4'd5, OP_AND = 4'd6, OP_XOR = 4'd7,
    OP_OR  = 4'd8, OP_CP  = 4'd9
  } alu_op_e;

  localparam int FLAG_W = 8;
  localparam int FS = 7;
  localparam int FZ = 6;
  localparam int FH = 4;
  localparam int FX = 3;
  localparam int FV = 2;
  localparam int FN = 1;
  localparam int FC = 0;
  localparam logic [FLAG_W-1:0] FULL_MASK = 8'hDF;
endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/1ps
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic              cin_i,
  output logic [W-1:0]      res_o,
  output logic [FLAG_W-1:0] fval_o,
  output logic [FLAG_W-1:0] fmask_o
);
  localparam int NIB = W / 2;
  localparam logic [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINNEG = {1'b1, {(W-1){1'b0}}};

  logic           ci;
  logic [W:0]     sum;
  logic [NIB:0]   nsum;
  logic [W-1:0]   lsum;
  logic [W:0]     subtr;
  logic [W:0]     diff;
  logic [W+1:0]   sdiff;
  logic [W-1:0]   inc_r;
  logic [W-1:0]   dec_r;
  logic           borrow;
  logic           nib_borrow;
  logic           s_ovf;

  assign ci    = ((op_i == OP_ADC) || (op_i == OP_SBC)) ? cin_i : 1'b0;
  assign sum   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci};
  assign nsum  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, ci};
  assign lsum  = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, ci};
  assign subtr = {1'b0, b_i} + {{W{1'b0}}, ci};
  assign diff  = {1'b0, a_i} - subtr;
  assign sdiff = {{2{a_i[W-1]}}, a_i} - {{2{b_i[W-1]}}, b_i} - {{(W+1){1'b0}}, ci};
  assign inc_r = a_i + ONE;
  assign dec_r = a_i - ONE;
  assign borrow     = ({1'b0, a_i} < subtr);
  assign nib_borrow = (a_i[NIB-1:0] < subtr[NIB-1:0]);
  assign s_ovf      = !((sdiff[W+1] == sdiff[W]) && (sdiff[W] == sdiff[W-1]));

  always_comb begin
    res_o   = '0;
    fval_o  = '0;
    fmask_o = '0;
    case (op_i)
      OP_INC: begin
        res_o = inc_r;
        fmask_o[FS] = 1'b1; fval_o[FS] = inc_r[W-1];
        fmask_o[FZ] = 1'b1; fval_o[FZ] = (inc_r == '0);
        fmask_o[FH] = 1'b1; fval_o[FH] = (inc_r[NIB-1:0] == '0);
        fmask_o[FX] = 1'b1; fval_o[FX] = (a_i == {W{1'b1}});
        fmask_o[FV] = (a_i == MAXPOS); fval_o[FV] = 1'b1;
      end
      OP_DEC: begin
        res_o = dec_r;
        fmask_o[FS] = 1'b1; fval_o[FS] = dec_r[W-1];
        fmask_o[FZ] = 1'b1; fval_o[FZ] = (dec_r == '0);
        fmask_o[FH] = 1'b1; fval_o[FH] = (dec_r[NIB-1:0] == '0);
        fmask_o[FX] = 1'b1; fval_o[FX] = (a_i == '0);
        fmask_o[FN] = 1'b1; fval_o[FN] = 1'b1;
        fmask_o[FV] = (a_i == MINNEG); fval_o[FV] = 1'b1;
      end
      OP_ADD, OP_ADC: begin
        res_o   = sum[W-1:0];
        fmask_o = FULL_MASK;
        fval_o[FS] = sum[W-1];
        fval_o[FZ] = (sum[W-1:0] == '0);
        fval_o[FH] = nsum[NIB];
        fval_o[FX] = sum[W];
        fval_o[FV] = sum[W] ^ lsum[W-1];
        fval_o[FN] = 1'b0;
        fval_o[FC] = sum[W];
      end
      OP_SUB, OP_SBC, OP_CP: begin
        res_o = diff[W-1:0];
        fmask_o[FS] = 1'b1; fval_o[FS] = diff[W-1];
        fmask_o[FZ] = 1'b1; fval_o[FZ] = (diff[W-1:0] == '0);
        fmask_o[FH] = 1'b1; fval_o[FH] = nib_borrow;
        fmask_o[FV] = 1'b1; fval_o[FV] = s_ovf;
        fmask_o[FN] = 1'b1; fval_o[FN] = 1'b1;
        fmask_o[FC] = 1'b1; fval_o[FC] = borrow;
        if (op_i != OP_SBC) begin
          fmask_o[FX] = borrow; fval_o[FX] = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  output logic [W-1:0]      res_o,
  output logic [FLAG_W-1:0] fval_o,
  output logic [FLAG_W-1:0] fmask_o
);
  logic [W-1:0] r;
  logic         hit;

  always_comb begin
    hit = 1'b1;
    case (op_i)
      OP_AND:  r = a_i & b_i;
      OP_XOR:  r = a_i ^ b_i;
      OP_OR:   r = a_i | b_i;
      default: begin r = '0; hit = 1'b0; end
    endcase
  end

  always_comb begin
    res_o   = r;
    fval_o  = '0;
    fmask_o = hit ? FULL_MASK : '0;
    fval_o[FS] = r[W-1];
    fval_o[FZ] = (r == '0);
    fval_o[FH] = (op_i == OP_AND);
    fval_o[FV] = ~^r;
  end
endmodule

// File: rtl/alu8_flagreg.sv
`timescale 1ns/1ps
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [FLAG_W-1:0] d_i,
  output logic [FLAG_W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (upd_i) q_o <= d_i;
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_clear_R1: assert (q_o == '0);
  end

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(q_o));
endmodule

// File: rtl/alu8_flagged.sv
`timescale 1ns/1ps
module alu8_flagged
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  output logic [W-1:0]      result_o,
  output logic              wr_en_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [W-1:0]      ares, lres;
  logic [FLAG_W-1:0] aval, amask, lval, lmask;
  logic [FLAG_W-1:0] fval, fmask, fnext;
  logic              is_logic, op_ok, upd;

  alu8_arith #(.W(W)) u_arith (
    .op_i(op_i), .a_i(opa_i), .b_i(opb_i), .cin_i(flags_o[FC]),
    .res_o(ares), .fval_o(aval), .fmask_o(amask)
  );

  alu8_logic #(.W(W)) u_logic (
    .op_i(op_i), .a_i(opa_i), .b_i(opb_i),
    .res_o(lres), .fval_o(lval), .fmask_o(lmask)
  );

  assign is_logic = (op_i == OP_AND) || (op_i == OP_XOR) || (op_i == OP_OR);
  assign op_ok    = (op_i <= OP_CP);
  assign result_o = is_logic ? lres  : ares;
  assign fval     = is_logic ? lval  : aval;
  assign fmask    = is_logic ? lmask : amask;
  assign fnext    = (flags_o & ~fmask) | (fval & fmask);
  assign upd      = exec_i && op_ok;
  assign wr_en_o  = upd && (op_i != OP_CP);

  alu8_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .d_i(fnext), .q_o(flags_o)
  );

  assert_cp_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_CP) |-> !wr_en_o);
  assert_and_sets_h_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_AND) |=> flags_o[FH]);
  assert_add_xc_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_ADD) |=> (flags_o[FX] == flags_o[FC]));
  assert_dec_sets_n_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_DEC) |=> flags_o[FN]);
  assert_inc_ovf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_INC && opa_i == {1'b0, {(W-1){1'b1}}}) |=> flags_o[FV]);
  assert_bit5_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> $stable(flags_o[5]));
  assert_bad_op_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !op_ok) |=> $stable(flags_o));
endmodule

// File: tb/alu8_flagged_bench.sv
`timescale 1ns/1ps
module alu8_flagged_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] a = 8'd0;
  logic [7:0] b = 8'd0;
  logic [7:0] result;
  logic       wr_en;
  logic [7:0] flags;

  int checks = 0;
  int errors = 0;
  logic [7:0] mf = 8'h00;

  typedef struct { logic [7:0] f; string tag; } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  alu8_flagged u_alu8_flagged (
    .clk(clk), .rst_n(rst_n), .exec_i(exec), .op_i(op), .opa_i(a), .opb_i(b),
    .result_o(result), .wr_en_o(wr_en), .flags_o(flags)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, expv);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R2 inc";
      4'd1: return "R3 dec";
      4'd2, 4'd3: return "R4 add";
      4'd4: return "R5 sub";
      4'd5: return "R6 sbc";
      4'd6, 4'd7, 4'd8: return "R7 logic";
      4'd9: return "R8 cp";
      default: return "R9 badop";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input int x, input int y, input logic [7:0] f,
                       output logic [7:0] r, output logic [7:0] nf);
    int s, ci, t, sx, sy, sd;
    nf = f;
    r  = 8'h00;
    case (o)
      4'd0: begin
        r = 8'((x + 1) & 255);
        nf[7] = r[7]; nf[6] = (r == 0); nf[4] = (r[3:0] == 0); nf[3] = (x == 255);
        if (x == 127) nf[2] = 1'b1;
      end
      4'd1: begin
        r = 8'((x + 255) & 255);
        nf[7] = r[7]; nf[6] = (r == 0); nf[4] = (r[3:0] == 0); nf[3] = (x == 0);
        nf[1] = 1'b1;
        if (x == 128) nf[2] = 1'b1;
      end
      4'd2, 4'd3: begin
        ci = (o == 4'd3) ? int'(f[0]) : 0;
        s  = x + y + ci;
        r  = 8'(s & 255);
        nf[7] = r[7]; nf[6] = (r == 0);
        nf[4] = ((x & 15) + (y & 15) + ci) > 15;
        nf[3] = (s > 255); nf[0] = (s > 255);
        nf[2] = (s > 255) ^ (((x & 127) + (y & 127) + ci) > 127);
        nf[1] = 1'b0;
      end
      4'd4, 4'd5, 4'd9: begin
        ci = (o == 4'd5) ? int'(f[0]) : 0;
        t  = y + ci;
        r  = 8'((x - t + 512) & 255);
        sx = (x > 127) ? x - 256 : x;
        sy = (y > 127) ? y - 256 : y;
        sd = sx - sy - ci;
        nf[7] = r[7]; nf[6] = (r == 0);
        nf[4] = (x & 15) < (t & 15);
        nf[2] = (sd < -128) || (sd > 127);
        nf[1] = 1'b1;
        nf[0] = (x < t);
        if (o != 4'd5 && x < t) nf[3] = 1'b1;
      end
      4'd6, 4'd7, 4'd8: begin
        if (o == 4'd6)      r = 8'(x & y);
        else if (o == 4'd7) r = 8'(x ^ y);
        else                r = 8'(x | y);
        nf[7] = r[7]; nf[6] = (r == 0); nf[4] = (o == 4'd6);
        nf[3] = 1'b0; nf[2] = ($countones(r) % 2 == 0); nf[1] = 1'b0; nf[0] = 1'b0;
      end
      default: ;
    endcase
  endtask

  task automatic run(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y, input bit ex);
    logic [7:0] er, ef;
    bit valid;
    exp_t e;
    string tg;
    @(negedge clk);
    op = o; a = x; b = y; exec = ex;
    #1;
    tg = tag_of(o);
    model(o, int'(x), int'(y), mf, er, ef);
    valid = (o <= 4'd9);
    if (valid && o != 4'd9) chk(result == er, {tg, " result"}, result, er);
    chk(wr_en == (ex && valid && o != 4'd9), {"R10 wr_en ", tg}, wr_en, ex && valid && o != 4'd9);
    if (ex) mf = ef;
    e.f = mf;
    e.tag = ex ? {tg, " flags"} : "R9 idle hold";
    expq.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        #1;
        chk(flags == e.f, e.tag, flags, e.f);
      end
    end
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL R9 watchdog expired act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(flags == 8'h00, "R1 reset flags", flags, 0);
    rst_n = 1'b1;
    // increment and decrement corners
    run(4'd0, 8'h7F, 8'h00, 1'b1);
    run(4'd0, 8'hFF, 8'h00, 1'b1);
    run(4'd0, 8'h0E, 8'h00, 1'b1);
    run(4'd1, 8'h80, 8'h00, 1'b1);
    run(4'd1, 8'h00, 8'h00, 1'b1);
    run(4'd1, 8'h11, 8'h00, 1'b1);
    // add family and carry chain
    run(4'd2, 8'h80, 8'h80, 1'b1);
    run(4'd2, 8'h7F, 8'h01, 1'b1);
    run(4'd2, 8'hFF, 8'h01, 1'b1);
    run(4'd3, 8'h10, 8'h20, 1'b1);
    run(4'd3, 8'h0F, 8'h00, 1'b1);
    // subtract family and borrow chain
    run(4'd4, 8'h10, 8'h20, 1'b1);
    run(4'd5, 8'h00, 8'hFF, 1'b1);
    run(4'd4, 8'h80, 8'h01, 1'b1);
    run(4'd4, 8'h05, 8'h05, 1'b1);
    run(4'd5, 8'h7F, 8'hFF, 1'b1);
    // logic ops and parity
    run(4'd6, 8'hF0, 8'h3C, 1'b1);
    run(4'd7, 8'hF0, 8'h3C, 1'b1);
    run(4'd8, 8'h01, 8'h02, 1'b1);
    run(4'd8, 8'h00, 8'h00, 1'b1);
    // compare
    run(4'd9, 8'h42, 8'h42, 1'b1);
    run(4'd9, 8'h01, 8'h80, 1'b1);
    // no strobe, undefined op codes
    run(4'd2, 8'hFF, 8'hFF, 1'b0);
    run(4'd12, 8'h12, 8'h34, 1'b1);
    run(4'd15, 8'h00, 8'h00, 1'b1);
    // random sweep with flags carried over
    for (int i = 0; i < 800; i++) begin
      run(4'($urandom_range(0, 10)), 8'($urandom), 8'($urandom), ($urandom_range(0, 7) != 0));
    end
    // reset mid-run
    run(4'd1, 8'h00, 8'h00, 1'b1);
    @(negedge clk);
    exec = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(flags == 8'h00, "R1 reset mid-run", flags, 0);
    mf = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    run(4'd3, 8'h01, 8'h01, 1'b1);
    @(negedge clk);
    exec = 1'b0;
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule